// File: doc/BRIEF.md
# VBUS Fault Protection Sequencer

This block is the digital controller of a USB supply protection switch. Comparator flags arrive already digitized: the input is below the under-voltage level, the input is above the over-voltage level, and the input is below the over-voltage release level. Alongside them come a magnitude code for the over-voltage excursion, a junction temperature code and an active-low enable. From these the block decides when the load switch may close and when the open-drain acknowledge line is pulled low.

The switch closes only after the supply has been qualified. A supply that has just arrived, or one coming back from under-voltage, needs a long qualification. A supply coming back from over-voltage, once it has dropped below the release level, needs a shorter one. Over-voltage excursions are filtered on turn-off by a running sum of the excursion magnitude, so a large excursion trips sooner than a small one. A thermal trip uses a hysteresis band. Faults are ranked: over-temperature first, then over-voltage, then under-voltage. All delays are counted in clock cycles through a cycles-per-millisecond parameter.

Top module: `vbus_guard`

## Requirements
- R1: After reset the switch is open and the acknowledge pull-down is off. Once the under-voltage flag clears, the switch closes and the pull-down turns on after exactly STARTUP_MS*CYCLES_PER_MS clock edges, counted from the first edge that sees the flag low, with the over-voltage flag low throughout.
- R2: After an over-voltage fault the block waits while the release flag is low, however long that lasts. From the first edge that sees the release flag high with under-voltage low, it closes the switch after exactly RECOVER_MS*CYCLES_PER_MS edges.
- R3: An under-voltage flag seen at a clock edge opens the switch and releases acknowledge by the next cycle. The enable input has no effect on this.
- R4: With no fault active and qualification complete, acknowledge is pulled low. The switch is closed when the active-low enable is 0 and open when it is 1, while acknowledge stays pulled low.
- R5: A thermal fault latches when the temperature code is strictly greater than OT_TRIP, and releases only when the code is strictly less than OT_CLEAR. While it is latched the switch is open and acknowledge is released. When it releases with the supply inside the window, the switch closes again without a qualification delay.
- R6: While the over-voltage flag is high, each edge adds the magnitude code to a running sum that saturates at its maximum value. The sum clears on an edge where the flag is low. An over-voltage fault is taken on the edge after the sum reaches TRIP_LIMIT, so a short, small excursion leaves the switch closed.
- R7: A fault or a return of the fault flag during a qualification delay cancels that delay, and it restarts in full when the condition clears.
- R8: Over-temperature takes precedence over over-voltage and under-voltage. When the thermal fault releases, the block takes the path for the supply state at that moment: under-voltage leads to the full qualification, and a supply still above the release level leads to the over-voltage recovery path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_i | input | 1 | Supply below under-voltage level |
| ov_i | input | 1 | Supply above over-voltage level |
| ov_rel_i | input | 1 | Supply below over-voltage release level |
| ov_mag_i | input | MAG_W | Over-voltage excursion magnitude code |
| temp_i | input | TEMP_W | Junction temperature code |
| en_n_i | input | 1 | Active-low switch enable |
| sw_on_o | output | 1 | Load switch gate enable |
| ack_pd_o | output | 1 | Acknowledge pull-down enable (0 = released, high-Z) |

## Verification
The qualification delays are probed one edge before and one edge after their expected end. This separates the full start-up length from the shorter over-voltage recovery and from an immediate resume. Over-voltage excursions are applied with magnitude codes 1, 8 and 15. A brief small glitch must leave the switch closed, and each sustained excursion must trip on its own edge count, which checks that the filter weights by magnitude. Temperature codes at, just above and between the thresholds exercise the hysteresis band. Mixed faults, thermal with under-voltage and thermal with over-voltage, show that priority holds and that the block resumes on the correct path.

// File: rtl/vbus_guard.sv
module vbus_guard #(
  parameter int CYCLES_PER_MS = 1000,
  parameter int STARTUP_MS    = 17,
  parameter int RECOVER_MS    = 8,
  parameter int MAG_W         = 4,
  parameter int ACC_W         = 10,
  parameter int TRIP_LIMIT    = 64,
  parameter int TEMP_W        = 8,
  parameter int OT_TRIP       = 145,
  parameter int OT_CLEAR      = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_i,
  input  logic              ov_i,
  input  logic              ov_rel_i,
  input  logic [MAG_W-1:0]  ov_mag_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              en_n_i,
  output logic              sw_on_o,
  output logic              ack_pd_o
);
  localparam int START_CYC = STARTUP_MS * CYCLES_PER_MS;
  localparam int REC_CYC   = RECOVER_MS * CYCLES_PER_MS;
  localparam int TMR_W     = $clog2((START_CYC > REC_CYC ? START_CYC : REC_CYC) + 1);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_READY, S_OVF, S_OVREC, S_OTF} st_t;

  st_t              state, nxt;
  logic [TMR_W-1:0] tmr;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   acc_sum;
  logic             ot_hot, ov_trip, restart;

  assign acc_sum  = {1'b0, acc} + (ACC_W+1)'(ov_mag_i);
  assign ov_trip  = acc >= ACC_W'(TRIP_LIMIT);
  assign restart  = (state == S_START) && ov_i;
  assign ack_pd_o = (state == S_READY);
  assign sw_on_o  = (state == S_READY) && !en_n_i;

  always_comb begin
    nxt = state;
    if (ot_hot) nxt = S_OTF;
    else if (ov_trip) nxt = S_OVF;
    else begin
      case (state)
        S_IDLE:  if (!uv_i && !ov_i) nxt = S_START;
        S_START: if (uv_i) nxt = S_IDLE;
                 else if (!ov_i && tmr == TMR_W'(START_CYC - 1)) nxt = S_READY;
        S_READY: if (uv_i) nxt = S_IDLE;
        S_OVF:   if (uv_i) nxt = S_IDLE;
                 else if (ov_rel_i) nxt = S_OVREC;
        S_OVREC: if (uv_i) nxt = S_IDLE;
                 else if (!ov_rel_i) nxt = S_OVF;
                 else if (tmr == TMR_W'(REC_CYC - 1)) nxt = S_READY;
        S_OTF:   if (uv_i) nxt = S_IDLE;
                 else if (!ov_rel_i) nxt = S_OVF;
                 else nxt = S_READY;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      tmr    <= '0;
      acc    <= '0;
      ot_hot <= 1'b0;
    end else begin
      state <= nxt;
      if (!ov_i) acc <= '0;
      else if (acc_sum[ACC_W]) acc <= ACC_MAX;
      else acc <= acc_sum[ACC_W-1:0];
      if (temp_i > TEMP_W'(OT_TRIP)) ot_hot <= 1'b1;
      else if (temp_i < TEMP_W'(OT_CLEAR)) ot_hot <= 1'b0;
      if (nxt != state || restart) tmr <= '0;
      else if (state == S_START || state == S_OVREC) tmr <= tmr + 1'b1;
    end
  end

  a_r3_uv_opens: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (!sw_on_o && !ack_pd_o));

  a_r4_sw_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    sw_on_o |-> ack_pd_o);

  a_r5_hot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_hot && $past(ot_hot)) |-> (!sw_on_o && !ack_pd_o));

  a_r6_sum_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ov_i) |-> (acc >= $past(acc)));

  a_r1_ack_from_qualify: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pd_o) |-> ($past(state) == S_START || $past(state) == S_OVREC || $past(state) == S_OTF));

  a_r8_hot_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_hot && (ov_trip || uv_i)) |=> (state == S_OTF));
endmodule

// File: tb/vbus_guard_tb.sv
module vbus_guard_tb;
  localparam int CPM = 4;
  localparam int ST  = 17 * CPM;
  localparam int RC  = 8 * CPM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uv = 1'b1, ov = 1'b0, ov_rel = 1'b1, en_n = 1'b0;
  logic [3:0] mag = '0;
  logic [7:0] temp = 8'd25;
  logic sw, ack;

  typedef struct { bit sw; bit ack; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vbus_guard #(.CYCLES_PER_MS(CPM), .ACC_W(8), .TRIP_LIMIT(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_i(uv), .ov_i(ov), .ov_rel_i(ov_rel),
    .ov_mag_i(mag), .temp_i(temp), .en_n_i(en_n), .sw_on_o(sw), .ack_pd_o(ack));

  task automatic expect_after(int n, bit esw, bit eack, string tag);
    exp_t e;
    repeat (n) @(posedge clk);
    #1;
    e.sw = esw; e.ack = eack; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (sw !== e.sw || ack !== e.ack) begin
        bad++;
        $display("FAIL %s: sw=%b ack=%b expected sw=%b ack=%b", e.tag, sw, ack, e.sw, e.ack);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    expect_after(2, 0, 0, "R1 reset state");
    settle(); rst_n = 1'b1;
    expect_after(3, 0, 0, "R1 idle while under-voltage");

    settle(); uv = 1'b0;
    expect_after(ST, 0, 0, "R1 still qualifying");
    expect_after(1, 1, 1, "R1 closes after start-up delay");

    settle(); en_n = 1'b1;
    expect_after(1, 0, 1, "R4 enable high opens switch, ack held");
    settle(); en_n = 1'b0;
    expect_after(1, 1, 1, "R4 enable low closes switch");

    settle(); ov = 1'b1; ov_rel = 1'b0; mag = 4'd1;
    expect_after(5, 1, 1, "R6 small short glitch tolerated");
    settle(); ov = 1'b0; ov_rel = 1'b1;
    expect_after(2, 1, 1, "R6 glitch gone");

    settle(); ov = 1'b1; ov_rel = 1'b0; mag = 4'd1;
    expect_after(16, 1, 1, "R6 magnitude 1 not yet tripped");
    expect_after(1, 0, 0, "R6 magnitude 1 trips");

    settle(); ov = 1'b0;
    expect_after(40, 0, 0, "R2 held above release level");
    settle(); ov_rel = 1'b1;
    expect_after(RC, 0, 0, "R2 recovery in progress");
    expect_after(1, 1, 1, "R2 closes after recovery delay");

    settle(); ov = 1'b1; ov_rel = 1'b0; mag = 4'd8;
    expect_after(2, 1, 1, "R6 magnitude 8 not yet tripped");
    expect_after(1, 0, 0, "R6 magnitude 8 trips faster");
    settle(); ov = 1'b0;
    expect_after(2, 0, 0, "R2 waiting for release");
    settle(); ov_rel = 1'b1;
    expect_after(RC + 1, 1, 1, "R2 second recovery");

    settle(); uv = 1'b1; en_n = 1'b0;
    expect_after(1, 0, 0, "R3 under-voltage opens at once");
    settle(); uv = 1'b0;
    expect_after(30, 0, 0, "R7 partway through start-up");
    settle(); uv = 1'b1;
    expect_after(1, 0, 0, "R7 start-up cancelled");
    settle(); uv = 1'b0;
    expect_after(ST, 0, 0, "R7 delay restarted in full");
    expect_after(1, 1, 1, "R7 closes after full restart");

    settle(); temp = 8'd145;
    expect_after(3, 1, 1, "R5 at trip code no shutdown");
    settle(); temp = 8'd146;
    expect_after(2, 0, 0, "R5 above trip code shuts down");
    settle(); temp = 8'd125;
    expect_after(10, 0, 0, "R5 inside hysteresis band");
    settle(); temp = 8'd120;
    expect_after(3, 0, 0, "R5 at clear code still off");
    settle(); temp = 8'd119;
    expect_after(1, 0, 0, "R5 release pending");
    expect_after(1, 1, 1, "R5 resumes without delay");

    settle(); temp = 8'd150;
    expect_after(2, 0, 0, "R8 thermal fault");
    settle(); uv = 1'b1;
    expect_after(1, 0, 0, "R8 thermal with under-voltage");
    settle(); temp = 8'd100;
    expect_after(5, 0, 0, "R8 resumes into under-voltage path");
    settle(); uv = 1'b0;
    expect_after(ST, 0, 0, "R8 full qualification after thermal");
    expect_after(1, 1, 1, "R8 closes after qualification");

    settle(); ov = 1'b1; ov_rel = 1'b0; mag = 4'd15;
    expect_after(2, 1, 1, "R6 magnitude 15 pending");
    expect_after(1, 0, 0, "R6 magnitude 15 trips");
    settle(); temp = 8'd150;
    expect_after(2, 0, 0, "R8 thermal over over-voltage");
    settle(); temp = 8'd100;
    expect_after(2, 0, 0, "R8 returns to over-voltage path");
    settle(); ov = 1'b0;
    expect_after(2, 0, 0, "R8 waiting for release");
    settle(); ov_rel = 1'b1;
    expect_after(RC, 0, 0, "R8 recovery length not start-up");
    expect_after(1, 1, 1, "R8 closes after recovery");

    settle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule